// File: doc/BRIEF.md
# NAND Pipelined Page Read Sequencer

This block is the device side of a flash read path that overlaps output with the array fetch. A host writes command and address bytes on an 8-bit bus. Each byte is qualified by a command-latch or address-latch enable and a one-cycle write strobe. After a setup command, a fixed number of address bytes and a confirm command, the sequencer pulls the addressed page from its internal array into a cache register. It moves that page into an output register and starts fetching the next page at once. While the host drains one page, the following page is already being fetched behind it. The read continues page after page until an exit command ends it.

Read data leaves through a valid/ready stream. A byte transfers on a rising clock edge where `dout_valid` and `dout_ready` are both high. While `dout_valid` is high and `dout_ready` is low, the byte is held unchanged. The consumer may hold `dout_ready` low for as long as it likes and nothing is lost. The active-low ready/busy pin reports the initial latency and any stall in which the output register has run dry. A status command switches the same output port to a status byte. A setup command issued during an active read switches the port back to data.

The array is modelled by a formula, not by storage. Fetch latencies are counted in clock cycles.

Top module: `nand_cache_read`

## Requirements
- R1: After reset, `rb_n` is 1, `dout_valid` is 0 and the output port is in data mode.
- R2: A read starts with command 0x00, followed by ADDR_CYCLES address bytes and then command 0x31. The first two address bytes are the column, low byte first. The remaining bytes form the page number, low byte first. Commands are bytes strobed by `we` with `cle`=1 and `ale`=0. Address bytes are strobed by `we` with `ale`=1 and `cle`=0.
- R3: In the cycle after an accepted 0x31, `rb_n` is 0. It stays 0 for exactly T_LAT+1 cycles and then returns to 1, while the next page is still being fetched.
- R4: If 0x31 arrives with a nonzero column, no read starts and `rb_n` stays 1. Status bit 0 becomes 1, and no data byte is offered. Bit 0 is cleared by the next accepted read.
- R5: Command 0x70 is accepted at any time, including during busy. It makes `dout_valid`=1 and `dout` carry the status byte, without consuming data. In the status byte, bit 5 = array idle, bit 6 = cache holds a complete page, bit 0 = column error, and all other bits = 0. Command 0x00 during an active read returns the port to data.
- R6: A data byte moves only on an edge where `dout_valid` and `dout_ready` are both 1. Under back-pressure, `dout` and `dout_valid` are held.
- R7: The byte at column c of page p equals ((p mod 256)·29 + c) mod 256, XORed with (p div 256) mod 256. Output starts at column 0 of the start page and runs through each column in order. It then continues with page p+1, p+2 and so on, with the page number wrapping at its width.
- R8: The next page's array fetch starts in the cycle a page enters the output register and takes T_FETCH cycles. Status bit 5 reads 0 during the fetch, and bit 6 reads 1 once the fetched page waits in the cache.
- R9: If the output register empties before the cache holds a page, `dout_valid` drops to 0 and `rb_n` is 0 until the page arrives.
- R10: Command 0x34 ends the read. Any fetch in progress and any cached page are discarded. The bytes left in the output register are still delivered, after which no data is offered and `rb_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_in | input | 8 | Command or address byte |
| cle | input | 1 | Byte on `io_in` is a command |
| ale | input | 1 | Byte on `io_in` is an address |
| we | input | 1 | One-cycle strobe that latches `io_in` |
| rb_n | output | 1 | Ready (1) / busy (0) |
| dout | output | 8 | Read data or status byte |
| dout_valid | output | 1 | `dout` carries a valid byte |
| dout_ready | input | 1 | Consumer accepts the byte on `dout` |

## Verification
Most internal faults surface within one page of output at the data port:
- A wrong page counter or column index shows as a content mismatch on the very next byte the scoreboard compares.
- A lost or duplicated register transfer shows as a byte that arrives out of order.
- A fetch that restarts late shows as an unexpected stall cycle, with `rb_n` low at a page boundary.

Faults in the fetch timer appear as a busy interval of the wrong length right after confirm, or as a status byte with a wrong bit 5 or bit 6 at a probed instant. A faulty exit path either delivers a page it should have dropped or withholds bytes still owed from the output register. Either case is visible once the stream should have gone quiet.

// File: rtl/nand_cr_pkg.sv
`timescale 1ns/1ps
package nand_cr_pkg;

  localparam logic [7:0] CMD_SETUP   = 8'h00;
  localparam logic [7:0] CMD_CONFIRM = 8'h31;
  localparam logic [7:0] CMD_EXIT    = 8'h34;
  localparam logic [7:0] CMD_STATUS  = 8'h70;

  typedef enum logic [1:0] {
    DEC_IDLE,
    DEC_ADDR,
    DEC_CONF
  } dec_state_e;

  // Modelled array content: one byte per (page, column).
  function automatic logic [7:0] page_byte(input logic [23:0] page, input logic [7:0] col);
    logic [7:0] mix;
    mix = page[7:0] * 8'd29 + col;
    return mix ^ page[15:8];
  endfunction

endpackage

// File: rtl/nand_cr_dec.sv
`timescale 1ns/1ps
module nand_cr_dec
  import nand_cr_pkg::*;
#(
  parameter int ADDR_CYCLES = 4,
  parameter int ROW_W       = 8 * (ADDR_CYCLES - 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       io_in,
  input  logic             cle,
  input  logic             ale,
  input  logic             we,
  input  logic             active,
  output logic             start,
  output logic             err_set,
  output logic             exit_cmd,
  output logic             stat_sel,
  output logic             err_q,
  output logic [ROW_W-1:0] start_page
);
  localparam int CNT_W   = $clog2(ADDR_CYCLES);
  localparam int ROW_BYT = ADDR_CYCLES - 2;

  dec_state_e                      state;
  logic [CNT_W-1:0]                cnt;
  logic [ADDR_CYCLES-1:0][7:0]     addr_q;
  logic                            cmd_hit, adr_hit, col_zero, conf;

  assign cmd_hit  = we && cle && !ale;
  assign adr_hit  = we && ale && !cle;
  assign col_zero = (addr_q[0] == 8'h00) && (addr_q[1] == 8'h00);
  assign conf     = cmd_hit && (io_in == CMD_CONFIRM) && (state == DEC_CONF) && !active;
  assign start    = conf && col_zero;
  assign err_set  = conf && !col_zero;
  assign exit_cmd = cmd_hit && (io_in == CMD_EXIT) && active;

  for (genvar i = 0; i < ROW_BYT; i++) begin : g_row
    assign start_page[8*i +: 8] = addr_q[2+i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= DEC_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      stat_sel <= 1'b0;
    end else if (cmd_hit) begin
      unique case (io_in)
        CMD_SETUP: begin
          stat_sel <= 1'b0;
          if (!active) begin
            state <= DEC_ADDR;
            cnt   <= '0;
          end
        end
        CMD_STATUS: stat_sel <= 1'b1;
        default:    state    <= DEC_IDLE;
      endcase
    end else if (adr_hit && state == DEC_ADDR) begin
      addr_q[cnt] <= io_in;
      cnt         <= cnt + 1'b1;
      if (cnt == CNT_W'(ADDR_CYCLES - 1)) state <= DEC_CONF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (start)   err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assert_err_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_q);
  assert_no_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !exit_cmd);

endmodule

// File: rtl/nand_cr_fetch.sv
`timescale 1ns/1ps
module nand_cr_fetch
  import nand_cr_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ROW_W      = 16,
  parameter int T_LAT      = 20,
  parameter int T_FETCH    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ROW_W-1:0]            start_page,
  input  logic                        exit_cmd,
  input  logic                        take,
  output logic                        active,
  output logic                        fetching,
  output logic                        cache_valid,
  output logic [PAGE_BYTES-1:0][7:0]  cache_q
);
  localparam int TMAX = (T_LAT > T_FETCH) ? T_LAT : T_FETCH;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0]                timer;
  logic [ROW_W-1:0]             page_q;
  logic [PAGE_BYTES-1:0][7:0]   fill;

  for (genvar c = 0; c < PAGE_BYTES; c++) begin : g_fill
    assign fill[c] = page_byte(24'(page_q), 8'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      fetching    <= 1'b0;
      cache_valid <= 1'b0;
      timer       <= '0;
      page_q      <= '0;
      cache_q     <= '0;
    end else if (start) begin
      active      <= 1'b1;
      fetching    <= 1'b1;
      cache_valid <= 1'b0;
      timer       <= TW'(T_LAT - 1);
      page_q      <= start_page;
    end else if (exit_cmd) begin
      active      <= 1'b0;
      fetching    <= 1'b0;
      cache_valid <= 1'b0;
    end else begin
      if (fetching) begin
        if (timer == '0) begin
          fetching    <= 1'b0;
          cache_valid <= 1'b1;
          cache_q     <= fill;
          page_q      <= page_q + 1'b1;
        end else begin
          timer <= timer - 1'b1;
        end
      end
      if (take) begin
        cache_valid <= 1'b0;
        fetching    <= 1'b1;
        timer       <= TW'(T_FETCH - 1);
      end
    end
  end

  assert_exit_drops_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_cmd && !start) |=> (!fetching && !cache_valid && !active));
  assert_cache_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && !take && !exit_cmd && !start) |=> (cache_valid && $stable(cache_q)));
  assert_refetch_on_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !exit_cmd && !start) |=> fetching);

endmodule

// File: rtl/nand_cr_out.sv
`timescale 1ns/1ps
module nand_cr_out #(
  parameter int PAGE_BYTES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       allow,
  input  logic                       cache_valid,
  input  logic [PAGE_BYTES-1:0][7:0] cache_q,
  input  logic                       fire,
  output logic                       take,
  output logic                       full,
  output logic [7:0]                 byte_o
);
  localparam int IW = $clog2(PAGE_BYTES);

  logic [PAGE_BYTES-1:0][7:0] data_q;
  logic [IW-1:0]              idx;
  logic                       last_fire;

  assign last_fire = fire && (idx == IW'(PAGE_BYTES - 1));
  assign take      = allow && cache_valid && (!full || last_fire);
  assign byte_o    = data_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      idx    <= '0;
      data_q <= '0;
    end else if (flush) begin
      full <= 1'b0;
      idx  <= '0;
    end else if (take) begin
      data_q <= cache_q;
      full   <= 1'b1;
      idx    <= '0;
    end else if (last_fire) begin
      full <= 1'b0;
      idx  <= '0;
    end else if (fire) begin
      idx <= idx + 1'b1;
    end
  end

  assert_hold_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !fire && !flush) |=> (full && $stable(idx) && $stable(byte_o)));
  assert_fire_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> full);

endmodule

// File: rtl/nand_cache_read.sv
`timescale 1ns/1ps
module nand_cache_read #(
  parameter int ADDR_CYCLES = 4,
  parameter int PAGE_BYTES  = 16,
  parameter int T_LAT       = 20,
  parameter int T_FETCH     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_in,
  input  logic       cle,
  input  logic       ale,
  input  logic       we,
  output logic       rb_n,
  output logic [7:0] dout,
  output logic       dout_valid,
  input  logic       dout_ready
);
  localparam int ROW_W = 8 * (ADDR_CYCLES - 2);

  logic                       start, err_set, exit_cmd, stat_sel, err_q;
  logic [ROW_W-1:0]           start_page;
  logic                       active, fetching, cache_valid;
  logic [PAGE_BYTES-1:0][7:0] cache_q;
  logic                       take, full, fire;
  logic [7:0]                 byte_o, status;

  nand_cr_dec #(.ADDR_CYCLES(ADDR_CYCLES), .ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_in(io_in), .cle(cle), .ale(ale), .we(we),
    .active(active), .start(start), .err_set(err_set), .exit_cmd(exit_cmd),
    .stat_sel(stat_sel), .err_q(err_q), .start_page(start_page)
  );

  nand_cr_fetch #(.PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .T_LAT(T_LAT), .T_FETCH(T_FETCH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .exit_cmd(exit_cmd), .take(take), .active(active), .fetching(fetching),
    .cache_valid(cache_valid), .cache_q(cache_q)
  );

  nand_cr_out #(.PAGE_BYTES(PAGE_BYTES)) u_out (
    .clk(clk), .rst_n(rst_n), .flush(start), .allow(active && !exit_cmd),
    .cache_valid(cache_valid), .cache_q(cache_q), .fire(fire),
    .take(take), .full(full), .byte_o(byte_o)
  );

  assign fire       = !stat_sel && full && dout_ready;
  assign status     = {1'b0, cache_valid, !fetching, 4'b0000, err_q};
  assign dout_valid = stat_sel ? 1'b1 : full;
  assign dout       = stat_sel ? status : byte_o;
  assign rb_n       = !(active && !full);

  assert_busy_on_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rb_n);
  assert_bad_column_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> rb_n);
  assert_status_idle_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_sel && fetching) |-> (dout_valid && !dout[5]));

endmodule

// File: tb/nand_cache_read_test.sv
`timescale 1ns/1ps
module nand_cache_read_test;
  localparam int PB   = 16;
  localparam int TLAT = 20;
  localparam int TF   = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_in = '0;
  logic       cle = 1'b0, ale = 1'b0, we = 1'b0;
  logic       dout_ready = 1'b0;
  logic       rb_n, dout_valid;
  logic [7:0] dout;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  nand_cache_read #(.ADDR_CYCLES(4), .PAGE_BYTES(PB), .T_LAT(TLAT), .T_FETCH(TF)) uut (
    .clk(clk), .rst_n(rst_n), .io_in(io_in), .cle(cle), .ale(ale), .we(we),
    .rb_n(rb_n), .dout(dout), .dout_valid(dout_valid), .dout_ready(dout_ready)
  );

  function automatic logic [7:0] model_byte(int p, int c);
    logic [7:0] a;
    a = 8'((p & 255) * 29 + c);
    return a ^ 8'((p >> 8) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(posedge clk); #1; io_in = b; cle = 1'b1; we = 1'b1;
    @(posedge clk); #1; cle = 1'b0; we = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] b);
    @(posedge clk); #1; io_in = b; ale = 1'b1; we = 1'b1;
    @(posedge clk); #1; ale = 1'b0; we = 1'b0;
  endtask

  task automatic push_page(input int p);
    for (int c = 0; c < PB; c++) expq.push_back(model_byte(p, c));
  endtask

  // Drains n bytes; returns the number of stall cycles seen (valid low, busy low).
  task automatic read_n(input int n, output int stalls);
    int got = 0;
    int guard = 0;
    stalls = 0;
    @(posedge clk); #1; dout_ready = 1'b1;
    while (got < n && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (dout_valid) got++;
      else if (!rb_n) stalls++;
    end
    @(posedge clk); #1; dout_ready = 1'b0;
    check(got == n, "R7 byte count", 8'(got), 8'(n));
  endtask

  // Scoreboard monitor: a handshake at the next edge pops one expected byte.
  always @(negedge clk) begin
    if (rst_n && dout_valid && dout_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R10 unexpected byte", dout, 8'h00);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(dout == e, "R7 data", dout, e);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int busy;
    int st;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rb_n == 1'b1, "R1 rb_n", {7'd0, rb_n}, 8'h01);
    check(dout_valid == 1'b0, "R1 valid", {7'd0, dout_valid}, 8'h00);

    send_cmd(8'h70);
    @(negedge clk);
    check(dout_valid && dout == 8'h20, "R5 idle status", dout, 8'h20);

    // R4: nonzero column rejected
    send_cmd(8'h00); send_addr(8'h05); send_addr(8'h00); send_addr(8'h03); send_addr(8'h00);
    send_cmd(8'h31);
    @(negedge clk);
    check(rb_n == 1'b1, "R4 stays ready", {7'd0, rb_n}, 8'h01);
    send_cmd(8'h70);
    @(negedge clk);
    check(dout == 8'h21, "R4 error bit", dout, 8'h21);
    send_cmd(8'h00);
    repeat (3) @(negedge clk);
    check(dout_valid == 1'b0, "R4 no data", {7'd0, dout_valid}, 8'h00);

    // R2/R3: read starting at page 3
    send_cmd(8'h00); send_addr(8'h00); send_addr(8'h00); send_addr(8'h03); send_addr(8'h00);
    send_cmd(8'h31);
    @(negedge clk);
    check(rb_n == 1'b0, "R3 busy after confirm", {7'd0, rb_n}, 8'h00);
    busy = 0;
    while (!rb_n && busy < 500) begin busy++; @(negedge clk); end
    check(busy == TLAT + 1, "R3 busy length", 8'(busy), 8'(TLAT + 1));

    send_cmd(8'h70);
    @(negedge clk);
    check(dout == 8'h00, "R8 fetch running", dout, 8'h00);
    repeat (TF + 5) @(negedge clk);
    check(dout == 8'h60, "R8 cache full", dout, 8'h60);
    send_cmd(8'h00);
    @(negedge clk);
    check(dout_valid && dout == model_byte(3, 0), "R5 back to data", dout, model_byte(3, 0));

    push_page(3); push_page(4); push_page(5);
    read_n(3 * PB, st);
    check(st > 0, "R9 stall seen", 8'(st), 8'h01);
    check(expq.size() == 0, "R7 all pages", 8'(expq.size()), 8'h00);

    // R10: exit while next page is still being fetched, nothing owed
    send_cmd(8'h34);
    @(posedge clk); #1; dout_ready = 1'b1;
    repeat (TF + 10) @(negedge clk);
    check(dout_valid == 1'b0, "R10 no more data", {7'd0, dout_valid}, 8'h00);
    check(rb_n == 1'b1, "R10 ready", {7'd0, rb_n}, 8'h01);
    @(posedge clk); #1; dout_ready = 1'b0;

    // R10: page in output register still delivered, page behind it dropped
    send_cmd(8'h00); send_addr(8'h00); send_addr(8'h00); send_addr(8'hFF); send_addr(8'h01);
    send_cmd(8'h31);
    send_cmd(8'h70);
    @(negedge clk);
    check(dout_valid && dout == 8'h00, "R5 status while busy", dout, 8'h00);
    send_cmd(8'h00);
    busy = 0;
    while (!rb_n && busy < 500) begin busy++; @(negedge clk); end
    repeat (TF + 5) @(negedge clk);
    push_page(16'h01FF);
    read_n(PB, st);
    send_cmd(8'h34);
    push_page(16'h0200);
    read_n(PB, st);
    @(posedge clk); #1; dout_ready = 1'b1;
    repeat (TF + 10) @(negedge clk);
    @(posedge clk); #1; dout_ready = 1'b0;
    check(expq.size() == 0, "R10 owed page out", 8'(expq.size()), 8'h00);
    check(dout_valid == 1'b0 && rb_n == 1'b1, "R10 quiet", {6'd0, dout_valid, rb_n}, 8'h01);
    send_cmd(8'h70);
    @(negedge clk);
    check(dout == 8'h20, "R10 idle status", dout, 8'h20);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule